// File: doc/BRIEF.md
# Sensor SPI Frame Slave

This block is the device end of a sixteen-bit, full-duplex serial port on a multi-channel sensor. The pins carry a chip select (low while a frame is active), a serial clock that idles low, and a data input. The block drives a serial data output together with a separate output enable for the pad's tri-state driver. All three pin inputs are brought into the system clock through synchronizers, and their edges are found there, so the serial clock must run well below the system clock.

Each frame does two things at once. It shifts in a configuration word that can choose one of four twelve-bit sample sources (rate, temperature, auxiliary 1, auxiliary 2) and one of two output codings. It also shifts out a reply made of two leading zeros, the two-bit source address and the twelve-bit sample, MSB first. A new configuration takes effect only when its frame runs to all sixteen clocks, so every reply uses the setting committed by an earlier frame. The block drives a hold strobe to the converter from frame start until the fourteenth clock. It also keeps a sticky flag that records a committed configuration word whose fixed bits are wrong.

Top module: `spi_sensor_port`

## Requirements
- R1: While cs_n is high, sdo_oe is 0, and serial clock or data activity changes neither the configuration nor any output.
- R2: A falling cs_n opens a frame. Three system clock edges later, sdo_oe is 1, sdo is 0 and hold is 1.
- R3: The reply bits are, in order: 0 at frame start, 0 after the first serial clock falling edge, then address bit 1, address bit 0 and sample bits 11 down to 0, each bit changing after a falling edge. After the sixteenth falling edge, sdo_oe returns to 0.
- R4: Configuration bits 11:10 select the source: 00 rate, 01 temperature, 10 auxiliary 1, 11 auxiliary 2. The reply's address field carries the code in force.
- R5: Configuration bit 4 selects the coding. With 0, the twelve-bit field equals the input sample (two's complement). With 1, it is offset binary: the sample with bit 11 inverted, so 0x000 gives 0x800, 0x800 gives 0x000 and 0x7FF gives 0xFFF.
- R6: Bit 15 of the word shifted in (the first bit sent) is the write flag. A word with bit 15 equal to 0 leaves the configuration unchanged.
- R7: A written configuration is committed on the sixteenth falling edge. The reply of that same frame still uses the previous configuration, and the next frame uses the new one.
- R8: If cs_n rises before sixteen falling edges, the configuration is kept as it was.
- R9: hold is 1 from frame start until the fourteenth serial clock falling edge, or until cs_n rises if that comes first.
- R10: After reset, the source is rate, the coding is two's complement, and sdo_oe, hold and proto_err are 0.
- R11: A committed write word that has bit 14 at 1, bit 5 at 1, or bits 9:8 other than 11 still updates the configuration and sets proto_err. proto_err then stays at 1 until reset. A word with bit 15 at 0 never sets it.
- R12: The sample is captured when the frame opens. A later change on the sample inputs does not alter that frame's reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select from the pin, low during a frame |
| sclk | input | 1 | Serial clock from the pin, idle low |
| sdi | input | 1 | Serial data from the pin |
| rate_smp | input | 12 | Rate sample, source 00 |
| temp_smp | input | 12 | Temperature sample, source 01 |
| aux1_smp | input | 12 | Auxiliary input 1 sample, source 10 |
| aux2_smp | input | 12 | Auxiliary input 2 sample, source 11 |
| sdo | output | 1 | Serial reply bit |
| sdo_oe | output | 1 | Output enable for the sdo pad driver |
| hold | output | 1 | Track/hold strobe, 1 while holding |
| proto_err | output | 1 | Sticky flag for a bad fixed-bit pattern |

## Verification
Each pin edge takes two synchronizer flops and one edge-detect flop to reach the logic, so sdo, sdo_oe and hold respond on the third system clock edge after the pin changes. The bench's reference model delays its own copy of the pins by the same amount, and the two are compared at every falling system clock edge. Pins change only on falling system clock edges, and each serial clock phase lasts four system clocks. A reply bit is therefore read just before the next rising serial clock, a full cycle after it is due. Configuration effects are one frame behind: they are checked in the frame after the write, and in the frame after a short or idle-time burst.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int SMP_W      = 12;
  localparam int ADR_W      = 2;
  localparam int FRAME_W    = SMP_W + ADR_W + 2;
  localparam int CNT_W      = $clog2(FRAME_W + 1);
  localparam int HOLD_FALLS = FRAME_W - 2;
  localparam int NSRC       = 1 << ADR_W;

  // bit positions inside the received configuration word
  localparam int B_WR   = FRAME_W - 1;
  localparam int B_Z0   = FRAME_W - 2;
  localparam int B_ADR  = 10;
  localparam int B_ONE  = 8;
  localparam int B_Z1   = 5;
  localparam int B_CODE = 4;

  typedef enum logic [ADR_W-1:0] {
    SRC_RATE = 2'd0,
    SRC_TEMP = 2'd1,
    SRC_AUX1 = 2'd2,
    SRC_AUX2 = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic offs;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{src: SRC_RATE, offs: 1'b0};
endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
  parameter int W = 3,
  parameter int E = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [E-1:0] prv
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      prv <= RST_VAL[E-1:0];
    end else begin
      chain[0] <= pin;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prv <= chain[STAGES-1][E-1:0];
    end
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/sfp_frame.sv
module sfp_frame
  import sfp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cs_fall,
  input  logic  cs_rise,
  input  logic  sclk_fall,
  input  logic  din_lvl,
  output logic  shift_ev,
  output logic  last_ev,
  output logic  track_ev,
  output logic  cfg_wr,
  output logic  cfg_bad,
  output ctrl_t cfg_new
);
  logic               active;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-2:0] rx;
  logic [FRAME_W-1:0] nxt;

  assign nxt      = {rx, din_lvl};
  assign shift_ev = active & sclk_fall & ~cs_rise & ~cs_fall & (cnt < CNT_W'(FRAME_W));
  assign last_ev  = shift_ev & (cnt == CNT_W'(FRAME_W - 1));
  assign track_ev = shift_ev & (cnt == CNT_W'(HOLD_FALLS - 1));

  // decode of the word as it stands once the current bit is in
  assign cfg_wr       = last_ev & nxt[B_WR];
  assign cfg_bad      = nxt[B_Z0] | nxt[B_Z1] | ~(&nxt[B_ONE+1:B_ONE]);
  assign cfg_new.src  = src_e'(nxt[B_ADR+ADR_W-1:B_ADR]);
  assign cfg_new.offs = nxt[B_CODE];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      rx     <= '0;
    end else if (cs_fall) begin
      active <= 1'b1;
      cnt    <= '0;
      rx     <= '0;
    end else if (cs_rise) begin
      active <= 1'b0;
    end else if (shift_ev) begin
      rx  <= nxt[FRAME_W-2:0];
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sfp_tx.sv
module sfp_tx
  import sfp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               shift_ev,
  input  logic               last_ev,
  input  logic               stop,
  output logic               dout,
  output logic               dout_oe
);
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else if (load) begin
      sh      <= load_word;
      dout    <= load_word[FRAME_W-1];
      dout_oe <= 1'b1;
    end else if (stop || last_ev) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else if (shift_ev) begin
      sh   <= sh << 1;
      dout <= sh[FRAME_W-2];
    end
  end
endmodule

// File: rtl/spi_sensor_port.sv
module spi_sensor_port
  import sfp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic [SMP_W-1:0] rate_smp,
  input  logic [SMP_W-1:0] temp_smp,
  input  logic [SMP_W-1:0] aux1_smp,
  input  logic [SMP_W-1:0] aux2_smp,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             hold,
  output logic             proto_err
);
  localparam int NPIN = 3;
  localparam int NEDGE = 2;
  localparam logic [NPIN-1:0] PIN_RST = 3'b001;

  logic [NPIN-1:0]  sync_lvl;
  logic [NEDGE-1:0] sync_prv;
  logic cs_fall, cs_rise, sclk_fall;
  logic shift_ev, last_ev, track_ev, cfg_wr, cfg_bad;
  ctrl_t cfg_new, ctrl_q;

  logic [SMP_W-1:0]   smp [NSRC];
  logic [SMP_W-1:0]   picked, coded;
  logic [FRAME_W-1:0] tx_word;

  // order: chip select, serial clock (both edge-detected), then data
  sfp_sync #(
    .W(NPIN), .E(NEDGE), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)
  ) i_sync (
    .clk(clk), .rst(rst), .pin({sdi, sclk, cs_n}), .lvl(sync_lvl), .prv(sync_prv)
  );

  assign cs_fall   = sync_prv[0] & ~sync_lvl[0];
  assign cs_rise   = ~sync_prv[0] & sync_lvl[0];
  assign sclk_fall = sync_prv[1] & ~sync_lvl[1];

  sfp_frame i_frame (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .din_lvl(sync_lvl[2]),
    .shift_ev(shift_ev), .last_ev(last_ev), .track_ev(track_ev),
    .cfg_wr(cfg_wr), .cfg_bad(cfg_bad), .cfg_new(cfg_new)
  );

  assign smp[SRC_RATE] = rate_smp;
  assign smp[SRC_TEMP] = temp_smp;
  assign smp[SRC_AUX1] = aux1_smp;
  assign smp[SRC_AUX2] = aux2_smp;

  assign picked  = smp[ctrl_q.src];
  assign coded   = {picked[SMP_W-1] ^ ctrl_q.offs, picked[SMP_W-2:0]};
  assign tx_word = {2'b00, ctrl_q.src, coded};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RST;
      proto_err <= 1'b0;
      hold      <= 1'b0;
    end else begin
      if (cfg_wr) begin
        ctrl_q    <= cfg_new;
        proto_err <= proto_err | cfg_bad;
      end
      if (cs_fall)                hold <= 1'b1;
      else if (cs_rise || track_ev) hold <= 1'b0;
    end
  end

  sfp_tx i_tx (
    .clk(clk), .rst(rst), .load(cs_fall), .load_word(tx_word),
    .shift_ev(shift_ev), .last_ev(last_ev), .stop(cs_rise),
    .dout(sdo), .dout_oe(sdo_oe)
  );
endmodule

// File: rtl/sfp_port_chk.sv
module sfp_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_lvl,
  input logic       cs_fall,
  input logic       cs_rise,
  input logic       shift_ev,
  input logic       cfg_wr,
  input logic [2:0] ctrl,
  input logic       sdo,
  input logic       sdo_oe,
  input logic       hold,
  input logic       proto_err
);
  p_hiz_idle_r1: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> !sdo_oe);

  p_open_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> !sdo);

  p_dout_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (!cs_fall && !cs_rise && !shift_ev) |=> $stable(sdo));

  p_ctrl_commit_only_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(ctrl));

  p_hold_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
    hold |-> sdo_oe);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  p_err_on_write_r11: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(proto_err));
endmodule

bind spi_sensor_port sfp_port_chk i_chk (
  .clk(clk), .rst(rst), .cs_lvl(sync_lvl[0]), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .shift_ev(shift_ev), .cfg_wr(cfg_wr), .ctrl(ctrl_q), .sdo(sdo), .sdo_oe(sdo_oe),
  .hold(hold), .proto_err(proto_err)
);

// File: tb/test_spi_sensor_port.sv
module test_spi_sensor_port;
  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [11:0] rate_smp = 12'h123, temp_smp = 12'h456, aux1_smp = 12'h789, aux2_smp = 12'hABC;
  logic sdo, sdo_oe, hold, proto_err;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] rx;

  always #4 clk = ~clk;

  spi_sensor_port i_spi_sensor_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .rate_smp(rate_smp), .temp_smp(temp_smp), .aux1_smp(aux1_smp), .aux2_smp(aux2_smp),
    .sdo(sdo), .sdo_oe(sdo_oe), .hold(hold), .proto_err(proto_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int src, input int off, input logic [11:0] s);
    logic [11:0] c;
    c = s;
    if (off != 0) c[11] = ~c[11];
    return {2'b00, 2'(src), c};
  endfunction

  // ---------------- behavioural reference model ----------------
  bit q1_cs = 1, q2_cs = 1, q3_cs = 1, q1_sc, q2_sc, q3_sc, q1_di, q2_di;
  bit m_oe, m_dout, m_hold, m_err, m_act;
  int m_src, m_off, m_n, m_in;
  bit m_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_oe = 0; m_dout = 0; m_hold = 0; m_err = 0; m_act = 0;
      m_src = 0; m_off = 0; m_n = 0; m_in = 0;
      q1_cs = 1; q2_cs = 1; q3_cs = 1; q1_sc = 0; q2_sc = 0; q3_sc = 0; q1_di = 0; q2_di = 0;
    end else begin
      if (q3_cs && !q2_cs) begin
        logic [11:0] s;
        logic [15:0] w;
        case (m_src)
          0: s = rate_smp;
          1: s = temp_smp;
          2: s = aux1_smp;
          default: s = aux2_smp;
        endcase
        w = exp_word(m_src, m_off, s);
        m_q.delete();
        for (int i = 15; i >= 0; i--) m_q.push_back(w[i]);
        m_dout = m_q.pop_front();
        m_oe = 1; m_hold = 1; m_act = 1; m_n = 0; m_in = 0;
      end else if (!q3_cs && q2_cs) begin
        m_act = 0; m_oe = 0; m_dout = 0; m_hold = 0;
      end else if (m_act && q3_sc && !q2_sc && m_n < 16) begin
        m_in = ((m_in << 1) | int'(q2_di)) & 16'hFFFF;
        m_n++;
        if (m_n == 14) m_hold = 0;
        if (m_n == 16) begin
          m_oe = 0; m_dout = 0;
          if (m_in[15]) begin
            m_src = (m_in >> 10) & 3;
            m_off = (m_in >> 4) & 1;
            if (m_in[14] || m_in[5] || !m_in[9] || !m_in[8]) m_err = 1;
          end
        end else begin
          m_dout = m_q.pop_front();
        end
      end
      q3_cs = q2_cs; q2_cs = q1_cs; q1_cs = cs_n;
      q3_sc = q2_sc; q2_sc = q1_sc; q1_sc = sclk;
      q2_di = q1_di; q1_di = sdi;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3", "sdo_oe vs model", int'(sdo_oe), int'(m_oe));
      if (m_oe) check("R3", "sdo vs model", int'(sdo), int'(m_dout));
      check("R9", "hold vs model", int'(hold), int'(m_hold));
      check("R11", "proto_err vs model", int'(proto_err), int'(m_err));
    end
  end

  // ---------------- stimulus ----------------
  task automatic frame(input logic [15:0] tx, input int nclk, input int poke_at,
                       input logic [11:0] poke_val, output logic [15:0] got);
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    check("R2", "sdo_oe at open", int'(sdo_oe), 1);
    got = '0;
    for (int k = 0; k < nclk; k++) begin
      check("R9", "hold before rise", int'(hold), int'(k < 14));
      if (k == poke_at) rate_smp = poke_val;
      sdi = tx[15-k];
      got = {got[14:0], sdo};
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
      repeat (4) @(negedge clk);
    end
    if (nclk == 16) check("R3", "sdo_oe after 16th fall", int'(sdo_oe), 0);
    cs_n = 1;
    repeat (6) @(negedge clk);
    sdi = 0;
    check("R1", "sdo_oe idle", int'(sdo_oe), 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    check("R10", "sdo_oe after reset", int'(sdo_oe), 0);
    check("R10", "hold after reset", int'(hold), 0);
    check("R10", "proto_err after reset", int'(proto_err), 0);

    frame(16'h0000, 16, -1, 12'h0, rx);
    check("R10", "default reply rate two's", int'(rx), int'(exp_word(0, 0, rate_smp)));

    frame(16'h8710, 16, -1, 12'h0, rx);
    check("R7", "write frame reply keeps old config", int'(rx), int'(exp_word(0, 0, rate_smp)));
    frame(16'h0B10, 16, -1, 12'h0, rx);
    check("R4", "temperature offset reply", int'(rx), 16'h1C56);
    frame(16'h0000, 16, -1, 12'h0, rx);
    check("R6", "read word leaves config", int'(rx), 16'h1C56);

    frame(16'h8B00, 16, -1, 12'h0, rx);
    frame(16'h0000, 16, -1, 12'h0, rx);
    check("R4", "aux1 two's reply", int'(rx), 16'h2789);
    frame(16'h8F10, 16, -1, 12'h0, rx);
    frame(16'h0000, 16, -1, 12'h0, rx);
    check("R5", "aux2 offset reply", int'(rx), 16'h32BC);

    frame(16'h8300, 10, -1, 12'h0, rx);
    frame(16'h0000, 16, -1, 12'h0, rx);
    check("R8", "short frame keeps config", int'(rx), 16'h32BC);

    // serial activity with chip select high
    w = 16'h8300;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk) sdi = w[15-k]; sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
      repeat (4) @(negedge clk);
      check("R1", "sdo_oe while deselected", int'(sdo_oe), 0);
    end
    sdi = 0;
    frame(16'h0000, 16, -1, 12'h0, rx);
    check("R1", "deselected clocks ignored", int'(rx), 16'h32BC);

    frame(16'h8310, 16, -1, 12'h0, rx);
    rate_smp = 12'h000;
    frame(16'h0000, 16, -1, 12'h0, rx);
    check("R5", "offset of 0x000", int'(rx), 16'h0800);
    rate_smp = 12'h800;
    frame(16'h0000, 16, -1, 12'h0, rx);
    check("R5", "offset of 0x800", int'(rx), 16'h0000);
    rate_smp = 12'h7FF;
    frame(16'h0000, 16, -1, 12'h0, rx);
    check("R5", "offset of 0x7FF", int'(rx), 16'h0FFF);

    check("R11", "no error after valid writes", int'(proto_err), 0);
    frame(16'h4000, 16, -1, 12'h0, rx);
    check("R11", "bad read word sets nothing", int'(proto_err), 0);
    frame(16'hC300, 16, -1, 12'h0, rx);
    check("R11", "bad write sets flag", int'(proto_err), 1);
    frame(16'h8310, 16, -1, 12'h0, rx);
    check("R11", "bad write still committed", int'(rx), 16'h07FF);
    check("R11", "flag sticky", int'(proto_err), 1);

    rate_smp = 12'h111;
    frame(16'h0000, 16, 3, 12'h222, rx);
    check("R12", "reply uses sample at open", int'(rx), 16'h0911);
    frame(16'h0000, 16, -1, 12'h0, rx);
    check("R12", "next frame takes new sample", int'(rx), 16'h0A22);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule